// File: doc/BRIEF.md
# Timer-Gated Dual-Path Signature Observer

This block watches the I and Q output paths of one receive channel during a self-test. Each path owns a 16-bit signature register. While a test window is open, every valid 24-bit sample on a path is folded into that path's register. At the end of the window the register holds a compact fingerprint of the whole data stream, and the host compares it with a known-good value.

A single control write opens the window. The low 15 bits of the control word set how many valid samples the window lasts, and a countdown timer tracks what is left. The top bit of the control word picks the mode. In compress mode the registers act as multiple-input signature registers. In capture mode the compression is switched off, and each register simply takes the low part of the incoming word, which lets a host look at raw data through the same readback path.

The signatures, the remaining timer count and a done flag are all registered outputs that can be read at any time.

Top module: `sig_bist_observer`

## Requirements
- R1: After a synchronous reset, both signatures read 0xFFFF, the timer reads 0 and done is 1.
- R2: A cycle with ctrl_wr high sets both signatures to 0xFFFF on the next edge. The same edge loads the timer with ctrl_word[14:0] and latches the mode from ctrl_word[15], where 1 selects capture and 0 selects compress.
- R3: A cycle with in_valid high, a nonzero timer and no write lowers the timer by exactly one. The timer never wraps below zero.
- R4: In compress mode, an accepted sample d updates a signature s to (s<<1) ^ (s[15] ? 0x100B : 0) ^ f. Here f = d[15:0] ^ {8'h00, d[23:16]}, and all values are 16 bits.
- R5: In capture mode, an accepted sample sets the signature to d[15:0].
- R6: When in_valid is low, or when the timer is zero, both signatures and the timer keep their values. Samples that arrive after the window has expired therefore have no effect.
- R7: The I signature depends only on i_data and the Q signature depends only on q_data.
- R8: done equals 1 exactly when the timer reads 0. Once set, it stays set until the next control write loads a nonzero count. A write that loads a count of 0 leaves done at 1.
- R9: When ctrl_wr and in_valid are both high in the same cycle, the write takes effect and the sample is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_word | input | 16 | Bit 15 selects the mode (1 = capture); bits 14:0 set the window length |
| in_valid | input | 1 | Strobe that marks a valid sample on both paths |
| i_data | input | 24 | I path sample |
| q_data | input | 24 | Q path sample |
| sig_i | output | 16 | I path signature |
| sig_q | output | 16 | Q path signature |
| timer_val | output | 15 | Samples left in the window |
| done | output | 1 | High when the window has expired |

## Verification
The bench builds the block with its default parameters: 24-bit samples, 16-bit signatures and a 15-bit timer. It loads only short windows of at most about 40 samples, so every run drives the timer through expiry many times and keeps feeding samples past the end of the window. Gaps in the valid strobe, writes that land on a valid sample, zero-length windows and mode changes between writes are all exercised. Random 24-bit data sets the top byte often enough to test the folding step in both modes.

// File: rtl/sig_bist_pkg.sv
package sig_bist_pkg;

  typedef enum logic {
    SIG_COMPRESS = 1'b0,
    SIG_CAPTURE  = 1'b1
  } sig_mode_e;

  localparam int unsigned NUM_PATHS = 2;

endpackage

// File: rtl/bist_window_timer.sv
module bist_window_timer
  import sig_bist_pkg::*;
#(
  parameter int unsigned TIMER_W = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [TIMER_W-1:0] load_val,
  input  logic               mode_bit,
  input  logic               sample,
  output logic [TIMER_W-1:0] count_q,
  output logic               done_q,
  output sig_mode_e          mode_q,
  output logic               step
);

  localparam logic [TIMER_W-1:0] CNT_ZERO = '0;
  localparam logic [TIMER_W-1:0] CNT_ONE  = {{(TIMER_W-1){1'b0}}, 1'b1};

  // A sample is accepted only inside an open window and never on a write cycle.
  assign step = sample && !load && (count_q != CNT_ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= CNT_ZERO;
      done_q  <= 1'b1;
      mode_q  <= SIG_COMPRESS;
    end else if (load) begin
      count_q <= load_val;
      done_q  <= (load_val == CNT_ZERO);
      mode_q  <= sig_mode_e'(mode_bit);
    end else if (step) begin
      count_q <= count_q - CNT_ONE;
      done_q  <= (count_q == CNT_ONE);
    end
  end

endmodule

// File: rtl/sig_misr.sv
module sig_misr
  import sig_bist_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned SIG_W  = 16,
  parameter logic [SIG_W-1:0] POLY = 16'h100B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  input  sig_mode_e         mode,
  input  logic [DATA_W-1:0] data,
  output logic [SIG_W-1:0]  sig_q
);

  localparam logic [SIG_W-1:0] SEED = '1;

  logic [SIG_W-1:0] folded;
  logic [SIG_W-1:0] shifted;
  logic [SIG_W-1:0] next_sig;

  // Fold every input bit onto signature bit (k mod SIG_W).
  always_comb begin
    folded = '0;
    for (int k = 0; k < DATA_W; k++) begin
      folded[k % SIG_W] = folded[k % SIG_W] ^ data[k];
    end
  end

  always_comb begin
    shifted = {sig_q[SIG_W-2:0], 1'b0};
    if (sig_q[SIG_W-1]) shifted = shifted ^ POLY;
  end

  always_comb begin
    if (mode == SIG_CAPTURE) next_sig = data[SIG_W-1:0];
    else                     next_sig = shifted ^ folded;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) sig_q <= SEED;
    else if (step)    sig_q <= next_sig;
  end

endmodule

// File: rtl/sig_bist_observer.sv
module sig_bist_observer
  import sig_bist_pkg::*;
#(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned SIG_W   = 16,
  parameter int unsigned TIMER_W = 15,
  parameter logic [SIG_W-1:0] POLY = 16'h100B
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_wr,
  input  logic [TIMER_W:0]   ctrl_word,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  i_data,
  input  logic [DATA_W-1:0]  q_data,
  output logic [SIG_W-1:0]   sig_i,
  output logic [SIG_W-1:0]   sig_q,
  output logic [TIMER_W-1:0] timer_val,
  output logic               done
);

  sig_mode_e mode_q;
  logic      step;

  logic [DATA_W-1:0] path_data [NUM_PATHS];
  logic [SIG_W-1:0]  path_sig  [NUM_PATHS];

  assign path_data[0] = i_data;
  assign path_data[1] = q_data;

  bist_window_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ctrl_wr),
    .load_val (ctrl_word[TIMER_W-1:0]),
    .mode_bit (ctrl_word[TIMER_W]),
    .sample   (in_valid),
    .count_q  (timer_val),
    .done_q   (done),
    .mode_q   (mode_q),
    .step     (step)
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    sig_misr #(.DATA_W(DATA_W), .SIG_W(SIG_W), .POLY(POLY)) u_misr (
      .clk   (clk),
      .rst   (rst),
      .clear (ctrl_wr),
      .step  (step),
      .mode  (mode_q),
      .data  (path_data[p]),
      .sig_q (path_sig[p])
    );
  end

  assign sig_i = path_sig[0];
  assign sig_q = path_sig[1];

endmodule

// File: rtl/sig_bist_checker.sv
module sig_bist_checker #(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned SIG_W   = 16,
  parameter int unsigned TIMER_W = 15
) (
  input logic               clk,
  input logic               rst,
  input logic               ctrl_wr,
  input logic [TIMER_W:0]   ctrl_word,
  input logic               in_valid,
  input logic [DATA_W-1:0]  i_data,
  input logic [DATA_W-1:0]  q_data,
  input logic [SIG_W-1:0]   sig_i,
  input logic [SIG_W-1:0]   sig_q,
  input logic [TIMER_W-1:0] timer_val,
  input logic               done
);

  logic capture_r;
  always_ff @(posedge clk) begin
    if (rst)          capture_r <= 1'b0;
    else if (ctrl_wr) capture_r <= ctrl_word[TIMER_W];
  end

  AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (sig_i == '1) && (sig_q == '1) && (timer_val == $past(ctrl_word[TIMER_W-1:0]))); // R2

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && in_valid && timer_val != '0) |=> timer_val == $past(timer_val) - 1'b1); // R3

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && in_valid && timer_val != '0 && capture_r)
      |=> (sig_i == $past(i_data[SIG_W-1:0])) && (sig_q == $past(q_data[SIG_W-1:0]))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && (!in_valid || timer_val == '0))
      |=> $stable(sig_i) && $stable(sig_q) && $stable(timer_val)); // R6

  AST_DONE_ZERO: assert property (@(posedge clk) disable iff (rst)
    done == (timer_val == '0)); // R8

endmodule

bind sig_bist_observer sig_bist_checker #(
  .DATA_W(DATA_W), .SIG_W(SIG_W), .TIMER_W(TIMER_W)
) u_sig_bist_checker (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_word(ctrl_word),
  .in_valid(in_valid), .i_data(i_data), .q_data(q_data),
  .sig_i(sig_i), .sig_q(sig_q), .timer_val(timer_val), .done(done)
);

// File: tb/test_sig_bist_observer.sv
module test_sig_bist_observer;

  localparam int CLK_HALF = 5 / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_wr = 1'b0;
  logic [15:0] ctrl_word = '0;
  logic        in_valid = 1'b0;
  logic [23:0] i_data = '0;
  logic [23:0] q_data = '0;
  logic [15:0] sig_i, sig_q;
  logic [14:0] timer_val;
  logic        done;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] m_si, m_sq;
  logic [14:0] m_tmr;
  logic        m_cap;

  always #2.5 clk = ~clk;

  sig_bist_observer i_sig_bist_observer (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_word(ctrl_word),
    .in_valid(in_valid), .i_data(i_data), .q_data(q_data),
    .sig_i(sig_i), .sig_q(sig_q), .timer_val(timer_val), .done(done)
  );

  function automatic logic [15:0] exp_next(input logic [15:0] s, input logic [23:0] d,
                                           input logic cap);
    logic [15:0] f;
    logic [15:0] r;
    if (cap) return d[15:0];
    f = d[15:0] ^ {8'h00, d[23:16]};
    r = {s[14:0], 1'b0};
    if (s[15]) r = r ^ 16'h100B;
    return r ^ f;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "sig_i", {16'h0, sig_i}, {16'h0, m_si});
    chk(req, "sig_q", {16'h0, sig_q}, {16'h0, m_sq});
    chk(req, "timer", {17'h0, timer_val}, {17'h0, m_tmr});
    chk("R8", "done", {31'h0, done}, {31'h0, (m_tmr == 15'd0)});
  endtask

  // Drive one cycle, update the model at the edge, compare just after it.
  task automatic cyc(input logic wr, input logic [15:0] w, input logic v,
                     input logic [23:0] di, input logic [23:0] dq, input string req);
    ctrl_wr = wr; ctrl_word = w; in_valid = v; i_data = di; q_data = dq;
    @(posedge clk);
    if (wr) begin
      m_si = 16'hFFFF; m_sq = 16'hFFFF; m_tmr = w[14:0]; m_cap = w[15];
    end else if (v && m_tmr != 0) begin
      m_si = exp_next(m_si, di, m_cap);
      m_sq = exp_next(m_sq, dq, m_cap);
      m_tmr = m_tmr - 15'd1;
    end
    #1;
    chk_all(req);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_si = 16'hFFFF; m_sq = 16'hFFFF; m_tmr = '0; m_cap = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    chk("R1", "reset sig_i", {16'h0, sig_i}, 32'h0000FFFF);
    chk("R1", "reset sig_q", {16'h0, sig_q}, 32'h0000FFFF);
    chk("R1", "reset timer", {17'h0, timer_val}, 32'h0);
    chk("R1", "reset done", {31'h0, done}, 32'h1);

    // R2 and R4: a three-sample compress window with top-byte folding.
    cyc(1'b1, 16'h0003, 1'b0, '0, '0, "R2");
    cyc(1'b0, '0, 1'b1, 24'hA5_1234, 24'h00_0001, "R4");
    cyc(1'b0, '0, 1'b0, 24'hFF_FFFF, 24'hFF_FFFF, "R6");
    cyc(1'b0, '0, 1'b1, 24'h80_8000, 24'h7F_0000, "R4");
    cyc(1'b0, '0, 1'b1, 24'h00_0000, 24'hFF_00FF, "R3");
    // R6: samples after expiry are ignored.
    cyc(1'b0, '0, 1'b1, 24'h12_3456, 24'h65_4321, "R6");
    cyc(1'b0, '0, 1'b1, 24'hDE_ADBE, 24'hEF_0011, "R6");

    // R5: capture mode takes the low 16 bits of each path.
    cyc(1'b1, 16'h8002, 1'b0, '0, '0, "R2");
    cyc(1'b0, '0, 1'b1, 24'hAB_CDEF, 24'h12_3456, "R5");
    cyc(1'b0, '0, 1'b1, 24'h77_0102, 24'h88_0304, "R5");
    cyc(1'b0, '0, 1'b1, 24'h99_9999, 24'h99_9999, "R6");

    // R8: a zero-length window leaves done set.
    cyc(1'b1, 16'h0000, 1'b1, 24'h11_1111, 24'h22_2222, "R8");
    // R9: a write together with a valid sample discards the sample.
    cyc(1'b1, 16'h0005, 1'b1, 24'h33_3333, 24'h44_4444, "R9");
    // R7: identical Q data, different I data.
    cyc(1'b0, '0, 1'b1, 24'h00_1111, 24'h00_0000, "R7");
    cyc(1'b0, '0, 1'b1, 24'h00_2222, 24'h00_0000, "R7");

    // Random windows with gaps in the valid strobe.
    for (int r = 0; r < 40; r++) begin
      logic [15:0] w;
      w = {1'($urandom), 15'($urandom_range(0, 40))};
      cyc(1'b1, w, 1'($urandom), 24'($urandom), 24'($urandom), "R2");
      for (int c = 0; c < 60; c++) begin
        cyc(($urandom_range(0, 99) == 0), {1'($urandom), 15'($urandom_range(0, 40))},
            ($urandom_range(0, 3) != 0), 24'($urandom), 24'($urandom), "R4");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    if (CLK_HALF < 0) $display("clock");
  end

endmodule